// File: doc/BRIEF.md
# Searchable Word Store with Miss Flag

This block is a small associative store. Software-visible words can be written and read back by index, the same as in any plain register file. It can also take a search key, compare it against every stored word in the same cycle and report which words hold that exact value. Each word drives its own match line. The lines are collected into a match vector, and a single miss flag is raised when none of them is active. An encoded index of the lowest-numbered matching word is reported as well, for callers that want one position rather than the full vector.

Write data and the search key share one input bus. Because of this, a write, a read and a search cannot take place in the same cycle. When more than one enable is high, one of them is chosen by fixed priority and the others are dropped. Each word carries a valid bit that reset clears. A word that has never been written cannot match, even when its zeroed contents equal the key. All results are registered. Each result appears one cycle after its operation is sampled and then holds until the next operation of the same kind.

Top module: `assoc_store`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take these values after that edge: `rd_data`=0, `match_vec`=0, `miss`=1, `hit_idx`=0. Every word is also marked as not written.
- R2: A read of word `addr` loads that word's stored value onto `rd_data` at the clock edge where the read is sampled. A word that was never written reads as 0.
- R3: A search loads `match_vec` at the clock edge where it is sampled. Bit i of `match_vec` is 1 exactly when word i has been written and its value equals `din`.
- R4: `miss` is 1 exactly when `match_vec` has no bit set. It is updated at the same edge as `match_vec`.
- R5: A word that has not been written since reset never sets its match bit, whatever the key, including a key of 0.
- R6: `hit_idx` gives the lowest i with bit i of `match_vec` set. It is 0 when `miss` is 1.
- R7: When several enables are high in the same cycle, write wins over search and search wins over read. Only the winning operation has any effect.
- R8: A write at one edge is seen by a search sampled at the very next edge.
- R9: `rd_data` changes only on a read that takes effect. `match_vec`, `miss` and `hit_idx` change only on a search that takes effect.
- R10: When several words equal the key, all of their match bits are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW = clog2(WORDS) | Word index for read and write |
| din | input | WIDTH | Write data, or the search key during a search |
| wr_en | input | 1 | Write `din` into word `addr` |
| rd_en | input | 1 | Read word `addr` |
| srch_en | input | 1 | Compare `din` against all words |
| rd_data | output | WIDTH | Registered read result |
| match_vec | output | WORDS | Registered per-word match lines |
| miss | output | 1 | Registered flag, high when no word matched |
| hit_idx | output | AW | Registered index of lowest matching word |

## Verification
Any fault in a word's stored value or valid bit shows up at the ports on the first search whose key touches that word. The wrong match bit appears one cycle after the search, and `miss` and `hit_idx` follow from it in the same cycle. A corrupted value is also seen on the first read of that word, one cycle after the read is sampled. The reference model is compared against the outputs after every edge. A wrong priority decision is therefore caught in the cycle that follows the conflicting enables, because an output that should have held changes value.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // Operation selected for one cycle; the shared data bus allows one at most.
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_SEARCH = 2'd2,
        OP_READ   = 2'd3
    } cam_op_e;

    // Decoded per-cycle control, carried as one bundle through the datapath.
    typedef struct packed {
        cam_op_e op;
        logic    do_write;
        logic    do_search;
        logic    do_read;
    } cam_ctl_t;

    // Fixed priority: write, then search, then read.
    function automatic cam_op_e pick_op(input logic wr, input logic srch, input logic rd);
        if (wr)
            return OP_WRITE;
        else if (srch)
            return OP_SEARCH;
        else if (rd)
            return OP_READ;
        return OP_NONE;
    endfunction

    function automatic cam_ctl_t make_ctl(input cam_op_e op);
        cam_ctl_t c;
        c.op        = op;
        c.do_write  = (op == OP_WRITE);
        c.do_search = (op == OP_SEARCH);
        c.do_read   = (op == OP_READ);
        return c;
    endfunction

endpackage

// File: rtl/cam_op_decode.sv
module cam_op_decode
    import cam_pkg::*;
(
    input  logic     wr_en,
    input  logic     rd_en,
    input  logic     srch_en,
    output cam_ctl_t ctl
);

    cam_op_e op_sel;

    always_comb begin
        op_sel = pick_op(wr_en, srch_en, rd_en);
        ctl    = make_ctl(op_sel);
    end

endmodule

// File: rtl/cam_word_row.sv
module cam_word_row #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] word_q,
    output logic             line_hit
);

    logic written_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            written_q <= 1'b0;
        end else if (load) begin
            word_q    <= wdata;
            written_q <= 1'b1;
        end
    end

    // Match line: only a written word may compare equal.
    always_comb begin
        line_hit = written_q && (word_q == key);
    end

endmodule

// File: rtl/cam_match_reduce.sv
module cam_match_reduce #(
    parameter int WORDS = 4,
    parameter int AW    = 2
) (
    input  logic [WORDS-1:0] lines,
    output logic             none_hit,
    output logic [AW-1:0]    first_idx
);

    always_comb begin
        none_hit  = ~|lines;
        first_idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (lines[i])
                first_idx = AW'(i);
        end
    end

endmodule

// File: rtl/assoc_store.sv
module assoc_store
    import cam_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int WIDTH = 8,
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             srch_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [WORDS-1:0] match_vec,
    output logic             miss,
    output logic [AW-1:0]    hit_idx
);

    cam_ctl_t         ctl;
    logic [WIDTH-1:0] row_word [WORDS];
    logic [WORDS-1:0] row_hit;
    logic [WORDS-1:0] row_load;
    logic             none_c;
    logic [AW-1:0]    idx_c;
    logic [WIDTH-1:0] rd_mux;

    cam_op_decode u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .srch_en (srch_en),
        .ctl     (ctl)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_row
        assign row_load[g] = ctl.do_write && (addr == AW'(g));

        cam_word_row #(.WIDTH(WIDTH)) u_row (
            .clk      (clk),
            .rst      (rst),
            .load     (row_load[g]),
            .wdata    (din),
            .key      (din),
            .word_q   (row_word[g]),
            .line_hit (row_hit[g])
        );
    end

    cam_match_reduce #(.WORDS(WORDS), .AW(AW)) u_red (
        .lines     (row_hit),
        .none_hit  (none_c),
        .first_idx (idx_c)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (addr == AW'(i))
                rd_mux = row_word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (ctl.do_read) begin
            rd_data <= rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_vec <= '0;
            miss      <= 1'b1;
            hit_idx   <= '0;
        end else if (ctl.do_search) begin
            match_vec <= row_hit;
            miss      <= none_c;
            hit_idx   <= idx_c;
        end
    end

endmodule

// File: rtl/assoc_store_chk.sv
module assoc_store_chk #(
    parameter int WORDS = 4,
    parameter int WIDTH = 8,
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic             srch_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [WORDS-1:0] match_vec,
    input logic             miss,
    input logic [AW-1:0]    hit_idx
);

    // Record of words written since reset, tracked from the ports only.
    logic [WORDS-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (wr_en)
            seen_q <= seen_q | (WORDS'(1) << addr);
    end

    assert_reset_vals_R1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && match_vec == '0 && miss && hit_idx == '0));

    assert_miss_nor_R4: assert property (@(posedge clk) disable iff (rst)
        miss == (match_vec == '0));

    assert_unwritten_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (match_vec & ~seen_q) == '0);

    assert_hit_lowest_R6: assert property (@(posedge clk) disable iff (rst)
        (match_vec != '0) |-> (match_vec[hit_idx] &&
            ((match_vec & ((WORDS'(1) << hit_idx) - WORDS'(1))) == '0)));

    assert_hit_zero_on_miss_R6: assert property (@(posedge clk) disable iff (rst)
        miss |-> (hit_idx == '0));

    assert_read_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en || srch_en || !rd_en) |=> $stable(rd_data));

    assert_search_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en || !srch_en) |=> ($stable(match_vec) && $stable(miss) && $stable(hit_idx)));

endmodule

bind assoc_store assoc_store_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .srch_en   (srch_en),
    .rd_data   (rd_data),
    .match_vec (match_vec),
    .miss      (miss),
    .hit_idx   (hit_idx)
);

// File: tb/tb_assoc_store.sv
module tb_assoc_store;

    localparam int WORDS = 4;
    localparam int WIDTH = 8;
    localparam int AW    = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] din = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             srch_en = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic [WORDS-1:0] match_vec;
    logic             miss;
    logic [AW-1:0]    hit_idx;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    assoc_store #(.WORDS(WORDS), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .wr_en(wr_en), .rd_en(rd_en), .srch_en(srch_en),
        .rd_data(rd_data), .match_vec(match_vec), .miss(miss), .hit_idx(hit_idx)
    );

    // Behavioural reference model
    int m_mem [WORDS];
    bit m_ok  [WORDS];
    int e_rd, e_match, e_miss, e_hit;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin m_mem[i] = 0; m_ok[i] = 0; end
            e_rd = 0; e_match = 0; e_miss = 1; e_hit = 0;
        end else if (wr_en) begin
            m_mem[addr] = din;
            m_ok[addr]  = 1;
        end else if (srch_en) begin
            e_match = 0;
            for (int i = 0; i < WORDS; i++)
                if (m_ok[i] && m_mem[i] == din) e_match = e_match | (1 << i);
            e_miss = (e_match == 0);
            e_hit = 0;
            for (int i = WORDS - 1; i >= 0; i--)
                if (e_match[i]) e_hit = i;
        end else if (rd_en) begin
            e_rd = m_mem[addr];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 rd_data model", int'(rd_data), e_rd);
            chk("R3 match_vec model", int'(match_vec), e_match);
            chk("R4 miss model", int'(miss), e_miss);
            chk("R6 hit_idx model", int'(hit_idx), e_hit);
        end
    end

    task automatic op(input bit we, input bit re, input bit se,
                      input int a, input int d);
        wr_en = we; rd_en = re; srch_en = se;
        addr = AW'(a); din = WIDTH'(d);
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; srch_en = 0;
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        // R1: reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 match_vec", int'(match_vec), 0);
        chk("R1 miss", int'(miss), 1);
        chk("R1 hit_idx", int'(hit_idx), 0);

        // R5: empty store, key 0 equals zeroed contents but nothing matches
        op(0, 0, 1, 0, 8'h00);
        chk("R5 empty search", int'(match_vec), 0);
        chk("R5 empty miss", int'(miss), 1);
        op(0, 1, 0, 2, 0);
        chk("R2 unwritten reads 0", int'(rd_data), 0);

        op(1, 0, 0, 0, 8'h5A);
        op(1, 0, 0, 1, 8'h33);
        op(1, 0, 0, 2, 8'h5A);
        op(1, 0, 0, 3, 8'h00);

        // R10, R6: two words match, lowest index reported
        op(0, 0, 1, 0, 8'h5A);
        chk("R10 multi match", int'(match_vec), 4'b0101);
        chk("R6 lowest hit", int'(hit_idx), 0);
        chk("R4 miss low on hit", int'(miss), 0);
        op(0, 0, 1, 0, 8'h00);
        chk("R3 written zero matches", int'(match_vec), 4'b1000);
        chk("R6 hit idx 3", int'(hit_idx), 3);

        op(0, 1, 0, 1, 0);
        chk("R2 read word1", int'(rd_data), 8'h33);

        // R7: all enables together -> write only
        op(1, 1, 1, 1, 8'h77);
        chk("R7 write beats read", int'(rd_data), 8'h33);
        chk("R7 write beats search", int'(match_vec), 4'b1000);
        // R7: search with read -> search only
        op(0, 1, 1, 1, 8'h77);
        chk("R7 search result", int'(match_vec), 4'b0010);
        chk("R7 search beats read", int'(rd_data), 8'h33);

        // R8: write followed directly by search
        wr_en = 1; addr = 0; din = 8'h77;
        @(posedge clk); #1;
        wr_en = 0; srch_en = 1;
        @(posedge clk); #1;
        srch_en = 0;
        @(negedge clk); #1;
        chk("R8 next-cycle search", int'(match_vec), 4'b0011);
        chk("R8 hit idx", int'(hit_idx), 0);

        // R9: idle cycles hold outputs
        repeat (2) @(negedge clk);
        chk("R9 hold match", int'(match_vec), 4'b0011);
        chk("R9 hold rd_data", int'(rd_data), 8'h33);
        op(0, 0, 1, 0, 8'hEE);
        chk("R4 miss on absent key", int'(miss), 1);
        chk("R6 idx zero on miss", int'(hit_idx), 0);

        // Mixed traffic checked by the model every cycle
        for (int k = 0; k < 400; k++) begin
            op(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
               int'($urandom % WORDS), int'($urandom % 4));
        end

        finish_run();
    end

endmodule